// File: doc/BRIEF.md
# Job-time predictor with voltage/frequency level selector

This block estimates, before a job runs, how many clock cycles that job will take and picks the slowest operating level that still finishes the job within its deadline. The estimate comes from the job's own input-derived features, not from the history of earlier jobs. It is a linear model: each feature value is multiplied by a trained signed coefficient and the products are summed. Running a job faster than its deadline needs brings no benefit, so the slowest level that meets the deadline is the one that saves the most energy.

The feature vector and a margin setting are captured on a start strobe. The dot product is formed with one multiply-accumulate per cycle. A negative result is clamped to zero. The estimate is then raised by a programmable fraction of itself, so that a close call tips toward meeting the deadline rather than toward saving energy. The raised estimate is compared against a table of per-level cycle budgets. Each budget is the level's frequency times the job deadline; for the usual 16.7 ms deadline, software computes the table once per frequency plan. Levels are indexed from slowest (0) to fastest.

Coefficients and budgets are loaded through a simple write port. Training the model, extracting features and driving the voltage regulator are handled elsewhere.

Top module: `exec_time_dvfs`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, pred_cycles, level and miss_risk are all zero, and every coefficient and budget is zero.
- R2: A start seen while busy is low raises busy on the next cycle. Exactly N_FEAT+2 clock edges after that start is sampled (10 with the defaults), done is high for a single cycle, and busy is low again in that same cycle.
- R3: The raw estimate is the sum over features i of feat_vec[i*16 +: 16] (unsigned) times coefficient i (16-bit signed), accumulated in 32-bit signed arithmetic. A negative sum is replaced by zero.
- R4: When margin_sh is nonzero, pred_cycles equals the clamped raw estimate plus that estimate shifted right by margin_sh bits. When margin_sh is zero, pred_cycles equals the clamped raw estimate.
- R5: level is the lowest index i for which pred_cycles <= budget[i]. Equality counts as meeting the budget.
- R6: If no budget is at least pred_cycles, level is N_LVL-1 (the fastest) and miss_risk is 1. Otherwise miss_risk is 0.
- R7: A start asserted while busy is ignored. Changes to feat_vec or margin_sh after the accepted start do not affect the running job.
- R8: With cfg_we high, cfg_sel=0 writes the low 16 bits of cfg_wdata to coefficient cfg_idx, and cfg_sel=1 writes cfg_wdata to the budget of level cfg_idx. An index beyond the table (coefficient >= N_FEAT, level >= N_LVL) writes nothing.
- R9: pred_cycles, level and miss_risk change only in the cycle in which done is high, and hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 1 | Table select: 0 coefficients, 1 level budgets |
| cfg_idx | input | 4 | Entry index within the selected table |
| cfg_wdata | input | 32 | Write data (coefficients use bits 15:0) |
| margin_sh | input | 3 | Safety margin shift; 0 disables the margin |
| feat_vec | input | 128 | Feature values, feature i in bits i*16 +: 16 |
| start | input | 1 | Start strobe for a new job |
| busy | output | 1 | A job estimate is in progress |
| done | output | 1 | One-cycle pulse when results update |
| pred_cycles | output | 32 | Margin-adjusted cycle estimate |
| level | output | 2 | Chosen level index, 0 = slowest |
| miss_risk | output | 1 | No level meets the deadline; fastest level chosen |

## Verification
On every cycle, the assertions check the handshake timing: busy after an accepted start, the fixed distance from that start to done, done lasting a single cycle, and the outputs holding between done pulses. They also check that a miss_risk flag always comes with the fastest level. The values themselves can only be shown by the bench's scenarios. These include the dot-product sum with mixed-sign coefficients, clamping of negative sums, each margin shift, the choice when the estimate exactly equals a budget, the overflow into miss_risk, out-of-range table writes, and a start issued in the middle of a job.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_TRIM = 2'd2,
    ST_PICK = 2'd3
  } dvfs_st_e;
endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int N_FEAT = 8,
  parameter int N_LVL  = 4,
  parameter int COEF_W = 16,
  parameter int BUD_W  = 32,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      sel,
  input  logic [IDX_W-1:0]          idx,
  input  logic [BUD_W-1:0]          wdata,
  output logic [N_FEAT*COEF_W-1:0]  coef_flat,
  output logic [N_LVL*BUD_W-1:0]    bud_flat
);
  for (genvar gi = 0; gi < N_FEAT; gi++) begin : g_coef
    logic              hit;
    logic [COEF_W-1:0] coef_q;
    assign hit = we && !sel && (32'(idx) == gi);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   coef_q <= '0;
      else if (hit) coef_q <= wdata[COEF_W-1:0];
    end
    assign coef_flat[gi*COEF_W +: COEF_W] = coef_q;
  end

  for (genvar gl = 0; gl < N_LVL; gl++) begin : g_bud
    logic             hit;
    logic [BUD_W-1:0] bud_q;
    assign hit = we && sel && (32'(idx) == gl);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bud_q <= '0;
      else if (hit) bud_q <= wdata;
    end
    assign bud_flat[gl*BUD_W +: BUD_W] = bud_q;
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int N_FEAT = 8,
  parameter int FEAT_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 32,
  parameter int SEL_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       en,
  input  logic [SEL_W-1:0]           sel,
  input  logic [N_FEAT*FEAT_W-1:0]   feat_flat,
  input  logic [N_FEAT*COEF_W-1:0]   coef_flat,
  output logic signed [ACC_W-1:0]    acc
);
  localparam int PROD_W = FEAT_W + COEF_W + 1;

  logic [FEAT_W-1:0]          feat_cur;
  logic signed [COEF_W-1:0]   coef_cur;
  logic signed [PROD_W-1:0]   prod;
  logic signed [ACC_W-1:0]    acc_d;
  logic signed [ACC_W-1:0]    acc_q;

  always_comb begin
    feat_cur = feat_flat[sel*FEAT_W +: FEAT_W];
    coef_cur = $signed(coef_flat[sel*COEF_W +: COEF_W]);
    prod     = $signed({1'b0, feat_cur}) * coef_cur;
    acc_d    = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_q + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc_q <= '0;
    else if (clr || en) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/level_pick.sv
module level_pick #(
  parameter int N_LVL = 4,
  parameter int BUD_W = 32,
  parameter int LVL_W = 2
) (
  input  logic [BUD_W-1:0]        pred,
  input  logic [N_LVL*BUD_W-1:0]  bud_flat,
  output logic [LVL_W-1:0]        lvl,
  output logic                    miss
);
  always_comb begin
    lvl  = LVL_W'(N_LVL - 1);
    miss = 1'b1;
    for (int i = N_LVL - 1; i >= 0; i--) begin
      if (pred <= bud_flat[i*BUD_W +: BUD_W]) begin
        lvl  = LVL_W'(i);
        miss = 1'b0;
      end
    end
  end
endmodule

// File: rtl/exec_time_dvfs.sv
module exec_time_dvfs #(
  parameter int N_FEAT = 8,
  parameter int FEAT_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 32,
  parameter int N_LVL  = 4,
  parameter int IDX_W  = 4,
  parameter int SH_W   = 3,
  localparam int SEL_W = (N_FEAT > 1) ? $clog2(N_FEAT) : 1,
  localparam int LVL_W = (N_LVL > 1) ? $clog2(N_LVL) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic                      cfg_sel,
  input  logic [IDX_W-1:0]          cfg_idx,
  input  logic [ACC_W-1:0]          cfg_wdata,
  input  logic [SH_W-1:0]           margin_sh,
  input  logic [N_FEAT*FEAT_W-1:0]  feat_vec,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic [ACC_W-1:0]          pred_cycles,
  output logic [LVL_W-1:0]          level,
  output logic                      miss_risk
);
  import dvfs_pkg::*;

  dvfs_st_e                 st_q, st_d;
  logic [SEL_W-1:0]         sel_q, sel_d;
  logic [N_FEAT*FEAT_W-1:0] feat_q;
  logic [SH_W-1:0]          sh_q;
  logic [ACC_W-1:0]         trim_q, trim_d;
  logic [ACC_W-1:0]         pred_q;
  logic [LVL_W-1:0]         lvl_q;
  logic                     miss_q, done_q;

  logic [N_FEAT*COEF_W-1:0] coef_flat;
  logic [N_LVL*ACC_W-1:0]   bud_flat;
  logic signed [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]         clamped;
  logic [LVL_W-1:0]         pick_lvl;
  logic                     pick_miss;
  logic                     accept, mac_en, trim_en, pick_en;

  coef_bank #(
    .N_FEAT(N_FEAT), .N_LVL(N_LVL), .COEF_W(COEF_W),
    .BUD_W(ACC_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .idx(cfg_idx), .wdata(cfg_wdata),
    .coef_flat(coef_flat), .bud_flat(bud_flat)
  );

  mac_unit #(
    .N_FEAT(N_FEAT), .FEAT_W(FEAT_W), .COEF_W(COEF_W),
    .ACC_W(ACC_W), .SEL_W(SEL_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(mac_en),
    .sel(sel_q), .feat_flat(feat_q), .coef_flat(coef_flat), .acc(acc)
  );

  level_pick #(
    .N_LVL(N_LVL), .BUD_W(ACC_W), .LVL_W(LVL_W)
  ) u_pick (
    .pred(trim_q), .bud_flat(bud_flat), .lvl(pick_lvl), .miss(pick_miss)
  );

  // next-state logic
  always_comb begin
    accept  = (st_q == ST_IDLE) && start;
    mac_en  = (st_q == ST_MAC);
    trim_en = (st_q == ST_TRIM);
    pick_en = (st_q == ST_PICK);
    st_d    = st_q;
    sel_d   = sel_q;
    clamped = acc[ACC_W-1] ? '0 : ACC_W'(acc);
    trim_d  = clamped + ((sh_q == '0) ? '0 : (clamped >> sh_q));
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_MAC;
        sel_d = '0;
      end
      ST_MAC: begin
        sel_d = sel_q + 1'b1;
        if (sel_q == SEL_W'(N_FEAT - 1)) st_d = ST_TRIM;
      end
      ST_TRIM: st_d = ST_PICK;
      ST_PICK: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      done_q <= pick_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_q <= '0;
      sh_q   <= '0;
    end else if (accept) begin
      feat_q <= feat_vec;
      sh_q   <= margin_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trim_q <= '0;
    else if (trim_en) trim_q <= trim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= '0;
      lvl_q  <= '0;
      miss_q <= 1'b0;
    end else if (pick_en) begin
      pred_q <= trim_q;
      lvl_q  <= pick_lvl;
      miss_q <= pick_miss;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign pred_cycles = pred_q;
  assign level       = lvl_q;
  assign miss_risk   = miss_q;
endmodule

// File: rtl/dvfs_chk.sv
module dvfs_chk #(
  parameter int N_FEAT = 8,
  parameter int N_LVL  = 4,
  parameter int ACC_W  = 32,
  parameter int LVL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ACC_W-1:0] pred_cycles,
  input logic [LVL_W-1:0] level,
  input logic             miss_risk
);
  localparam int LAT   = N_FEAT + 2;
  localparam int CNT_W = $clog2(LAT + 2) + 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start && !busy)  cnt_q <= '0;
    else if (busy)            cnt_q <= cnt_q + 1'b1;
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == CNT_W'(LAT) && !busy)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_MISS_FASTEST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && miss_risk) |-> (level == LVL_W'(N_LVL - 1))); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pred_cycles) && $stable(level) && $stable(miss_risk))); // R9
endmodule

bind exec_time_dvfs dvfs_chk #(
  .N_FEAT(N_FEAT), .N_LVL(N_LVL), .ACC_W(ACC_W), .LVL_W(LVL_W)
) u_dvfs_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pred_cycles(pred_cycles), .level(level), .miss_risk(miss_risk)
);

// File: tb/test_exec_time_dvfs.sv
module test_exec_time_dvfs;
  localparam int NF = 8;
  localparam int NV = 11;
  localparam int LAT = NF + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we, cfg_sel;
  logic [3:0]    cfg_idx;
  logic [31:0]   cfg_wdata;
  logic [2:0]    margin_sh;
  logic [NF*16-1:0] feat_vec;
  logic          start;
  logic          busy, done, miss_risk;
  logic [31:0]   pred_cycles;
  logic [1:0]    level;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exec_time_dvfs i_exec_time_dvfs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .margin_sh(margin_sh),
    .feat_vec(feat_vec), .start(start), .busy(busy), .done(done),
    .pred_cycles(pred_cycles), .level(level), .miss_risk(miss_risk)
  );

  // Coefficients 10,20,-5,3,0,7,1,2; budgets 1000,2000,4000,8000.
  // Columns: f0..f7, margin_sh, expected pred, level, miss_risk.
  localparam int TV [NV][12] = '{
    '{   0,  0,   0,  0, 0,  0, 0, 0, 0,    0, 0, 0},
    '{  50,  0,   0,  0, 0,  0, 0, 0, 0,  500, 0, 0},
    '{  50, 30,   0,  0, 0,  0, 0, 0, 3, 1237, 1, 0},
    '{   0,  0, 100,  0, 0,  0, 0, 0, 1,    0, 0, 0},
    '{ 100,100,   0,  0, 0,  0, 0, 0, 2, 3750, 2, 0},
    '{1000,  0,   0,  0, 0,  0, 0, 0, 0,10000, 3, 1},
    '{ 100,  0,   0,  0, 0,  0, 0, 0, 0, 1000, 0, 0},
    '{ 100,  0,   0,  0, 0,  0, 0, 1, 0, 1002, 1, 0},
    '{   0,  0,   1, 10, 0, 10, 5, 0, 1,  150, 0, 0},
    '{ 700,  0,   0,  0, 0,  0, 0, 0, 3, 7875, 3, 0},
    '{ 800,  0,   0,  0, 0,  0, 0, 0, 3, 9000, 3, 1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = 4'(idx); cfg_wdata = 32'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Starts a job and waits for done; returns negedges from start to done.
  task automatic run_job(input logic [NF*16-1:0] fv, input logic [2:0] sh, output int k);
    @(negedge clk);
    feat_vec = fv; margin_sh = sh; start = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end while (!done && k < 40);
  endtask

  function automatic logic [NF*16-1:0] row_feat(input int v);
    logic [NF*16-1:0] f;
    for (int j = 0; j < NF; j++) f[j*16 +: 16] = 16'(TV[v][j]);
    return f;
  endfunction

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    logic [NF*16-1:0] fv;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    margin_sh = '0; feat_vec = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 pred", pred_cycles, 0);
    chk("R1 level", 32'(level), 0);
    chk("R1 miss", 32'(miss_risk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, busy, done, miss_risk}, 0);

    // R8: load tables
    wr(0, 0, 10); wr(0, 1, 20); wr(0, 2, -5); wr(0, 3, 3);
    wr(0, 4, 0);  wr(0, 5, 7);  wr(0, 6, 1);  wr(0, 7, 2);
    wr(1, 0, 1000); wr(1, 1, 2000); wr(1, 2, 4000); wr(1, 3, 8000);

    // R3 R4 R5 R6 table of vectors
    for (int v = 0; v < NV; v++) begin
      run_job(row_feat(v), 3'(TV[v][8]), k);
      chk("R2 latency", 32'(k), 32'(LAT + 1));
      chk("R3/R4 pred", pred_cycles, 32'(TV[v][9]));
      chk("R5 level", 32'(level), 32'(TV[v][10]));
      chk("R6 miss_risk", 32'(miss_risk), 32'(TV[v][11]));
    end

    // R2: done lasts one cycle, busy already low
    chk("R2 busy at done", 32'(busy), 0);
    @(negedge clk);
    chk("R2 done single", 32'(done), 0);

    // R8: out-of-range writes land nowhere
    wr(0, 8, 999);
    wr(1, 4, 1);
    fv = '0; fv[15:0] = 16'd50;
    run_job(fv, 3'd0, k);
    chk("R8 coef idx 8 ignored", pred_cycles, 500);
    chk("R8 level idx 4 ignored", 32'(level), 0);

    // R8: budget rewrite moves the choice
    wr(1, 0, 400);
    run_job(fv, 3'd0, k);
    chk("R8 budget rewrite", 32'(level), 1);
    wr(1, 0, 1000);

    // R7: start while busy ignored, inputs captured at start
    @(negedge clk);
    feat_vec = fv; margin_sh = 3'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    fv = '0; fv[15:0] = 16'd700;
    feat_vec = fv; margin_sh = 3'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 4;
    while (!done && k < 40) begin @(negedge clk); k++; end
    chk("R7 latency unchanged", 32'(k), 32'(LAT + 1));
    chk("R7 first job features kept", pred_cycles, 500);
    begin
      int extra = 0;
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      chk("R7 no second job", 32'(extra), 0);
    end

    // R9: outputs hold between jobs
    feat_vec = '1; margin_sh = 3'd2;
    repeat (5) @(negedge clk);
    chk("R9 pred held", pred_cycles, 500);
    chk("R9 level held", 32'(level), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule